// File: doc/BRIEF.md
# Runtime-Addressable Delay Line

This block delays a multi-bit word stream by a number of clock cycles chosen while it runs. Each clock edge with the enable high pushes the input word into a chain of storage positions. A depth address picks which position is read out, so the latency of a datapath can be changed at any time without a reset. A typical use is to even out the latency of parallel pipeline branches whose cycle counts differ, or change with the mode.

The chain is made of segments of sixteen positions. The last position of each segment feeds the first position of the next. The low four bits of the depth address pick a position inside a segment. The bits above them pick the segment. Every bit of the word shares one depth address and one enable. A parameter adds an optional output flip-flop, which costs one more cycle. The stored words have no reset, in the same way as a lookup-table shifter, and they hold zero at the start of simulation.

Top module: `dyn_delay_line`

## Requirements
- R1: With no output register, depth address d gives a delay of d+1 enabled cycles: address 0 shows the word taken in at the most recent enabled edge.
- R2: The depth address is $clog2(16*STAGES) bits wide. Bits [3:0] select the position inside a segment and the upper bits select the segment. The largest delay is 16*STAGES cycles. An address beyond the chain reads the last position.
- R3: A word leaving position 15 of one segment enters position 0 of the next segment on the following enabled edge, so address 16 reads what address 15 read one enabled edge earlier.
- R4: With the enable low, no stored word changes on a clock edge and the input is ignored.
- R5: The output is a combinational read of the selected position, so a change of depth shows on the output in the same cycle and leaves the stored words unchanged.
- R6: All WIDTH bits of a word move together under one depth address and one enable.
- R7: With OUT_REG set, the output passes through one flip-flop loaded only on enabled edges, which adds one cycle: address d gives d+2 cycles of delay.
- R8: There is no reset input. All stored words and the output register start at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage moves on its rising edge |
| ce | input | 1 | Shift enable; storage holds while low |
| din | input | WIDTH | Word shifted into the chain |
| depth | input | DEPTH_W | Selected position; delay is depth+1 cycles, plus 1 with OUT_REG |
| dout | output | WIDTH | Word read from the selected position |

## Verification
The embedded assertions watch every cycle. They check that a low enable freezes the chain ends and the output register, that address 0 shows the word taken in on the last enabled edge, and that the first position of the second segment carries what the end of the first segment held one enabled edge before. Several things show only in the bench scenarios, where a queue model is compared with both outputs on every clock. These are the full delay for every address up to the largest delay, depth changes taking effect within the same cycle, the zero start without reset, and the extra cycle of the output register.

// File: rtl/dyn_delay_line.sv
module dyn_delay_line #(
  parameter int WIDTH     = 8,
  parameter int STAGES    = 2,
  parameter int SEG_DEPTH = 16,
  parameter bit OUT_REG   = 1'b0,
  localparam int TOTAL    = SEG_DEPTH * STAGES,
  localparam int DEPTH_W  = $clog2(TOTAL)
) (
  input  logic               clk,
  input  logic               ce,
  input  logic [WIDTH-1:0]   din,
  input  logic [DEPTH_W-1:0] depth,
  output logic [WIDTH-1:0]   dout
);

  logic [WIDTH-1:0] tap_all [TOTAL];
  logic [WIDTH-1:0] link    [STAGES+1];
  logic [WIDTH-1:0] sel_word;

  assign link[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_seg
    logic [WIDTH-1:0] mem [SEG_DEPTH] = '{default: '0};

    always_ff @(posedge clk) begin
      if (ce) begin
        mem[0] <= link[s];
        for (int k = 1; k < SEG_DEPTH; k++) mem[k] <= mem[k-1];
      end
    end

    assign link[s+1] = mem[SEG_DEPTH-1];
    for (genvar k = 0; k < SEG_DEPTH; k++) begin : g_tap
      assign tap_all[s*SEG_DEPTH + k] = mem[k];
    end
  end

  assign sel_word = (int'(depth) < TOTAL) ? tap_all[depth] : tap_all[TOTAL-1];

  if (OUT_REG) begin : g_oreg
    logic [WIDTH-1:0] q = '0;
    always_ff @(posedge clk) if (ce) q <= sel_word;
    assign dout = q;
  end else begin : g_ocomb
    assign dout = sel_word;
  end

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  // R4
  hold_ends_chk: assert property (@(posedge clk) disable iff (!primed)
    !ce |=> ($stable(tap_all[0]) && $stable(tap_all[TOTAL-1])));

  // R1
  newest_tap_chk: assert property (@(posedge clk) disable iff (!primed)
    ce |=> ((depth != '0) || (sel_word == $past(din))));

  if (STAGES > 1) begin : g_casc_chk
    // R3
    seg_link_chk: assert property (@(posedge clk) disable iff (!primed)
      ce |=> (tap_all[SEG_DEPTH] == $past(tap_all[SEG_DEPTH-1])));
  end

  if (OUT_REG) begin : g_oreg_chk
    // R7
    oreg_hold_chk: assert property (@(posedge clk) disable iff (!primed)
      !ce |=> $stable(dout));
  end

endmodule

// File: tb/dyn_delay_line_tb_top.sv
module dyn_delay_line_tb_top;
  localparam int W = 8;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         ce = 1'b0;
  logic [W-1:0] din = '0;
  logic [4:0]   depth = '0;
  logic [W-1:0] dout, dout_r;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] hist [N];
  logic [W-1:0] ref_q;

  always #5 clk = ~clk;

  dyn_delay_line #(.WIDTH(W), .STAGES(2), .OUT_REG(1'b0)) dut_i (
    .clk(clk), .ce(ce), .din(din), .depth(depth), .dout(dout));

  dyn_delay_line #(.WIDTH(W), .STAGES(1), .OUT_REG(1'b1)) dut_reg_i (
    .clk(clk), .ce(ce), .din(din), .depth(depth[3:0]), .dout(dout_r));

  task automatic step(input logic c, input logic [W-1:0] d, input logic [4:0] dp,
                      input string tag);
    @(negedge clk);
    ce = c; din = d; depth = dp;
    #1;
    tests++;
    if (dout !== hist[dp]) begin
      fails++;
      $display("FAIL %s depth=%0d actual=%h expected=%h", tag, dp, dout, hist[dp]);
    end
    tests++;
    if (dout_r !== ref_q) begin
      fails++;
      $display("FAIL R7 depth=%0d actual=%h expected=%h", dp[3:0], dout_r, ref_q);
    end
    @(posedge clk);
    if (c) begin
      ref_q = hist[dp[3:0]];
      for (int i = N-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = d;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) hist[i] = '0;
    ref_q = '0;
    // R8: zero start, no reset
    step(1'b0, 8'h11, 5'd0, "R8");
    step(1'b0, 8'h22, 5'd31, "R8");
    // R1: fill with a ramp, read newest
    for (int i = 0; i < 40; i++) step(1'b1, W'(i + 1), 5'd0, "R1");
    // R1: various fixed depths
    for (int i = 0; i < 20; i++) step(1'b1, W'(8'h40 + i), 5'd5, "R1");
    // R2: sweep all addresses with enable low, same-cycle depth change (R5)
    for (int i = 0; i < N; i++) step(1'b0, 8'hFF, 5'(i), "R5");
    // R2: maximum delay
    for (int i = 0; i < 10; i++) step(1'b1, W'(8'h80 + i), 5'd31, "R2");
    // R3: segment boundary addresses 15 and 16
    for (int i = 0; i < 12; i++) step(1'b1, W'(8'hC0 + i), (i % 2 == 0) ? 5'd15 : 5'd16, "R3");
    // R4: enable low ignores input
    for (int i = 0; i < 6; i++) step(1'b0, W'(8'hE0 + i), 5'd2, "R4");
    for (int i = 0; i < N; i++) step(1'b0, 8'h5A, 5'(N - 1 - i), "R4");
    // R6: full-width patterns
    for (int i = 0; i < 24; i++) step(1'b1, (i % 2 == 0) ? 8'hA5 : 8'h5A, 5'd1, "R6");
    // R5: depth changing every cycle while shifting
    for (int i = 0; i < 30; i++) step(i % 3 != 0, W'(i * 7), 5'((i * 11) % N), "R5");
    // R7: reg output with intermittent enable
    for (int i = 0; i < 20; i++) step(i % 2 == 0, W'(8'h30 + i), 5'd3, "R7");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule